// File: doc/BRIEF.md
# UART Receive Holding Register with Byte-Locked Status

This block sits between a UART bit-level receiver and a CPU register port. The receiver hands over each completed character together with three error indications: parity, framing and noise. The block keeps one character visible in a readable data register and presents a status word. The status word carries a receive-not-empty bit, the three per-character error bits and an overrun bit.

The central property is that the error bits shown always describe the character currently visible in the data register, and no other. When a second character completes while the first is still unread, overrun is raised. The second character and its own error bits are parked in a one-entry pending stage. That stage stays hidden until the data read that empties the register, and on that read it moves into the data register with its flags. While overrun is set, further characters are refused. Software clears overrun by reading the status word and then the data word. The receive-not-empty level doubles as the interrupt request.

Top module: `uart_rx_hold_top`

## Requirements
- R1: When a character completes (`in_valid` high) while the data register is empty and overrun is clear, the character is in `data_out` after that clock edge. Receive-not-empty is then set, and the error bits show that character's own parity, framing and noise indications.
- R2: A character in the data register stays unchanged in `data_out` until a data read (`rd_data`) occurs.
- R3: Status bit positions: bit 0 receive-not-empty, bit 1 parity error, bit 2 framing error, bit 3 noise error, bit 4 overrun. Bits 1 to 3 describe only the character in the data register and read as zero while the data register is empty.
- R4: A character that completes while the data register is full, with overrun clear and no data read in that cycle, sets overrun. It is parked with its three error bits in the pending stage and does not change `data_out` or bits 1 to 3.
- R5: While overrun is set, completed characters are discarded: neither the data register nor the pending stage changes.
- R6: A data read while a character is pending moves that character and its own error bits into the data register in the same cycle, and receive-not-empty stays set. A data read with nothing pending empties the register and clears receive-not-empty.
- R7: Overrun is cleared only by a data read preceded by a status read (`rd_status`) with no data read between them. A data read not preceded by a status read leaves overrun set.
- R8: Parity, framing and noise errors never block the acceptance of later characters.
- R9: A character that completes in the same cycle as a data read, with overrun clear, enters the data register directly without raising overrun.
- R10: `rx_irq` equals the receive-not-empty bit at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | One-cycle strobe: a character has completed |
| in_byte | input | DATA_W | Completed character |
| in_par_err | input | 1 | Parity error on the completed character |
| in_frm_err | input | 1 | Framing error on the completed character |
| in_nse_err | input | 1 | Noise error on the completed character |
| rd_status | input | 1 | Status read strobe |
| rd_data | input | 1 | Data read strobe |
| data_out | output | DATA_W | Data register contents |
| status_out | output | 5 | Status word (layout in R3) |
| rx_irq | output | 1 | Receive-not-empty level for interrupt routing |

## Verification
The hardest situation to reach is an overrun where the two characters carry different error sets. Only then can the pending stage's flags leaking early, or the register's flags surviving a promotion, be seen at the ports. The stimulus sends two back-to-back characters with no read between them, in both orders: erroneous then clean, and clean then erroneous. It then walks status and data reads one at a time, comparing the flags against the character shown after every read. A further sequence reads data without a status read, so that overrun outlives the promotion and a third character must be refused.

// File: rtl/uart_rxh_pkg.sv
package uart_rxh_pkg;
  typedef struct packed {
    logic par;
    logic frm;
    logic nse;
  } rxh_err_t;

  localparam int unsigned ST_RXNE = 0;
  localparam int unsigned ST_PAR  = 1;
  localparam int unsigned ST_FRM  = 2;
  localparam int unsigned ST_NSE  = 3;
  localparam int unsigned ST_OVR  = 4;
  localparam int unsigned ST_W    = 5;
endpackage

// File: rtl/rxh_hold_stage.sv
module rxh_hold_stage
  import uart_rxh_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic              clr_en,
  input  logic [DATA_W-1:0] d_byte,
  input  rxh_err_t          d_err,
  output logic              q_valid,
  output logic [DATA_W-1:0] q_byte,
  output rxh_err_t          q_err
);
  logic              valid_n;
  logic [DATA_W-1:0] byte_n;
  rxh_err_t          err_n;

  always_comb begin
    valid_n = q_valid;
    byte_n  = q_byte;
    err_n   = q_err;
    if (ld_en) begin
      valid_n = 1'b1;
      byte_n  = d_byte;
      err_n   = d_err;
    end else if (clr_en) begin
      valid_n = 1'b0;
      err_n   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_byte  <= '0;
      q_err   <= '0;
    end else if (ld_en || clr_en) begin
      q_valid <= valid_n;
      q_byte  <= byte_n;
      q_err   <= err_n;
    end
  end

  // R3
  empty_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !q_valid |-> (q_err == '0));
endmodule

// File: rtl/rxh_ovr_ctrl.sv
module rxh_ovr_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_status,
  input  logic rd_data,
  input  logic set_ovr,
  output logic ovr,
  output logic armed
);
  logic ovr_n;
  logic armed_n;

  always_comb begin
    armed_n = armed;
    if (rd_data)        armed_n = 1'b0;
    else if (rd_status) armed_n = 1'b1;

    ovr_n = ovr;
    if (rd_data && armed) ovr_n = 1'b0;
    else if (set_ovr)     ovr_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      ovr   <= 1'b0;
    end else begin
      armed <= armed_n;
      ovr   <= ovr_n;
    end
  end

  // R7
  ovr_clear_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovr) |-> $past(rd_data && armed));
endmodule

// File: rtl/uart_rx_hold_top.sv
module uart_rx_hold_top
  import uart_rxh_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_byte,
  input  logic              in_par_err,
  input  logic              in_frm_err,
  input  logic              in_nse_err,
  input  logic              rd_status,
  input  logic              rd_data,
  output logic [DATA_W-1:0] data_out,
  output logic [ST_W-1:0]   status_out,
  output logic              rx_irq
);
  rxh_err_t          in_err;
  logic              ovr, armed;
  logic              accept, d_free, set_ovr, promote;
  logic              d_v, p_v;
  logic [DATA_W-1:0] d_byte, p_byte, d_ld_byte;
  rxh_err_t          d_err, p_err, d_ld_err;
  logic              d_ld, d_clr;

  assign in_err  = '{par: in_par_err, frm: in_frm_err, nse: in_nse_err};

  // character acceptance and routing
  assign accept  = in_valid && !ovr;
  assign d_free  = !d_v || rd_data;
  assign set_ovr = accept && !d_free;
  assign promote = rd_data && p_v;

  always_comb begin
    d_ld      = 1'b0;
    d_clr     = 1'b0;
    d_ld_byte = in_byte;
    d_ld_err  = in_err;
    if (promote) begin
      d_ld      = 1'b1;
      d_ld_byte = p_byte;
      d_ld_err  = p_err;
    end else if (accept && d_free) begin
      d_ld      = 1'b1;
    end else if (rd_data) begin
      d_clr     = 1'b1;
    end
  end

  rxh_hold_stage #(.DATA_W(DATA_W)) data_reg_i (
    .clk(clk), .rst_n(rst_n),
    .ld_en(d_ld), .clr_en(d_clr),
    .d_byte(d_ld_byte), .d_err(d_ld_err),
    .q_valid(d_v), .q_byte(d_byte), .q_err(d_err)
  );

  rxh_hold_stage #(.DATA_W(DATA_W)) pend_reg_i (
    .clk(clk), .rst_n(rst_n),
    .ld_en(set_ovr), .clr_en(promote),
    .d_byte(in_byte), .d_err(in_err),
    .q_valid(p_v), .q_byte(p_byte), .q_err(p_err)
  );

  rxh_ovr_ctrl ovr_ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .rd_status(rd_status), .rd_data(rd_data),
    .set_ovr(set_ovr), .ovr(ovr), .armed(armed)
  );

  always_comb begin
    status_out          = '0;
    status_out[ST_RXNE] = d_v;
    status_out[ST_PAR]  = d_err.par;
    status_out[ST_FRM]  = d_err.frm;
    status_out[ST_NSE]  = d_err.nse;
    status_out[ST_OVR]  = ovr;
  end
  assign data_out = d_byte;
  assign rx_irq   = d_v;

  // R4
  pend_implies_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    p_v |-> (d_v && ovr));
  // R2
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (d_v && !rd_data) |=> $stable(data_out));
  // R4
  ovr_set_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> $past(in_valid && d_v && !rd_data));
  // R5
  blocked_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !rd_data) |=> $stable(p_byte) && $stable(data_out));
  // R6
  promote_keeps_rxne_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && p_v) |=> rx_irq);
endmodule

// File: tb/uart_rx_hold_top_tb_top.sv
`timescale 1ns/1ps
module uart_rx_hold_top_tb_top;
  localparam int unsigned DW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid, in_par_err, in_frm_err, in_nse_err;
  logic [DW-1:0] in_byte;
  logic          rd_status, rd_data;
  logic [DW-1:0] data_out;
  logic [4:0]    status_out;
  logic          rx_irq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  uart_rx_hold_top #(.DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .in_par_err(in_par_err), .in_frm_err(in_frm_err), .in_nse_err(in_nse_err),
    .rd_status(rd_status), .rd_data(rd_data),
    .data_out(data_out), .status_out(status_out), .rx_irq(rx_irq)
  );

  // bit0 rxne, bit1 parity, bit2 framing, bit3 noise, bit4 overrun
  function automatic logic [4:0] st(bit v, bit p, bit f, bit n, bit o);
    return {o, n, f, p, v};
  endfunction

  task automatic chk(string req, logic [4:0] exp_st, logic [DW-1:0] exp_d);
    checks++;
    if (status_out !== exp_st || rx_irq !== exp_st[0] ||
        (exp_st[0] && data_out !== exp_d)) begin
      errors++;
      $display("FAIL %s: status=%b irq=%b data=%h expected status=%b irq=%b data=%h",
               req, status_out, rx_irq, data_out, exp_st, exp_st[0], exp_d);
    end
  endtask

  task automatic send(logic [DW-1:0] b, bit p, bit f, bit n);
    @(negedge clk);
    in_valid = 1'b1; in_byte = b; in_par_err = p; in_frm_err = f; in_nse_err = n;
    @(negedge clk);
    in_valid = 1'b0; in_par_err = 1'b0; in_frm_err = 1'b0; in_nse_err = 1'b0;
  endtask

  task automatic rd_st();
    @(negedge clk); rd_status = 1'b1;
    @(negedge clk); rd_status = 1'b0;
  endtask

  task automatic rd_dt();
    @(negedge clk); rd_data = 1'b1;
    @(negedge clk); rd_data = 1'b0;
  endtask

  task automatic t_reset();
    chk("R3 reset", st(0,0,0,0,0), '0);
  endtask

  task automatic t_single();
    send(8'h3C, 0, 0, 0);
    chk("R1 single good", st(1,0,0,0,0), 8'h3C);
    repeat (3) @(negedge clk);
    chk("R2 held", st(1,0,0,0,0), 8'h3C);
    rd_st(); rd_dt();
    chk("R6 empty after read", st(0,0,0,0,0), '0);
  endtask

  task automatic t_bad_then_good();
    send(8'hA1, 1, 0, 0);
    chk("R1 parity byte", st(1,1,0,0,0), 8'hA1);
    send(8'hB2, 0, 0, 0);
    chk("R4 bad-good overrun", st(1,1,0,0,1), 8'hA1);
    rd_st();
    chk("R2 status read keeps data", st(1,1,0,0,1), 8'hA1);
    rd_dt();
    chk("R6 R7 bad-good promoted", st(1,0,0,0,0), 8'hB2);
    rd_dt();
    chk("R6 bad-good empty", st(0,0,0,0,0), '0);
  endtask

  task automatic t_good_then_bad();
    send(8'hC3, 0, 0, 0);
    send(8'hD4, 0, 1, 1);
    chk("R3 R4 good-bad flags hidden", st(1,0,0,0,1), 8'hC3);
    rd_st(); rd_dt();
    chk("R6 R7 good-bad promoted flags", st(1,0,1,1,0), 8'hD4);
    rd_st(); rd_dt();
    chk("R3 good-bad empty", st(0,0,0,0,0), '0);
  endtask

  task automatic t_block();
    send(8'h11, 0, 0, 0);
    send(8'h22, 0, 0, 1);
    send(8'h33, 1, 1, 1);
    chk("R5 third dropped, first kept", st(1,0,0,0,1), 8'h11);
    rd_st(); rd_dt();
    chk("R5 pending not replaced", st(1,0,0,1,0), 8'h22);
    rd_dt();
    chk("R5 third never arrived", st(0,0,0,0,0), '0);
    send(8'h44, 0, 0, 0);
    chk("R7 accepted after clear", st(1,0,0,0,0), 8'h44);
    rd_dt();
  endtask

  task automatic t_no_arm();
    send(8'h55, 0, 0, 0);
    send(8'h66, 1, 0, 0);
    rd_dt();
    chk("R7 unarmed read keeps overrun", st(1,1,0,0,1), 8'h66);
    send(8'h77, 0, 0, 0);
    chk("R5 blocked after promote", st(1,1,0,0,1), 8'h66);
    rd_dt();
    chk("R7 overrun outlives data", st(0,0,0,0,1), '0);
    send(8'h88, 0, 0, 0);
    chk("R5 blocked while empty", st(0,0,0,0,1), '0);
    rd_st(); rd_dt();
    chk("R7 cleared by status+data", st(0,0,0,0,0), '0);
    send(8'h99, 0, 1, 0);
    chk("R1 accepted again", st(1,0,1,0,0), 8'h99);
    rd_dt();
  endtask

  task automatic t_err_no_block();
    send(8'hE5, 1, 1, 1);
    chk("R8 all errors shown", st(1,1,1,1,0), 8'hE5);
    rd_dt();
    chk("R3 flags gone with byte", st(0,0,0,0,0), '0);
    send(8'hF6, 0, 0, 0);
    chk("R8 next byte accepted", st(1,0,0,0,0), 8'hF6);
    rd_dt();
  endtask

  task automatic t_same_cycle();
    send(8'h0A, 0, 0, 0);
    @(negedge clk);
    in_valid = 1'b1; in_byte = 8'h0B; in_nse_err = 1'b1; rd_data = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; in_nse_err = 1'b0; rd_data = 1'b0;
    chk("R9 R10 read with arrival", st(1,0,0,1,0), 8'h0B);
    rd_dt();
    chk("R10 irq low when empty", st(0,0,0,0,0), '0);
  endtask

  initial begin
    #800000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_byte = '0;
    in_par_err = 1'b0; in_frm_err = 1'b0; in_nse_err = 1'b0;
    rd_status = 1'b0; rd_data = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_bad_then_good();
    t_good_then_bad();
    t_block();
    t_no_arm();
    t_err_no_block();
    t_same_cycle();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule